// File: doc/BRIEF.md
# Shared-Unit Multiply-Add Datapath

This block evaluates z = a*b + c + d for a stream of operand sets. It has exactly one multiplier and one adder. The multiplier needs two cycles. The adder needs one cycle and is shared between two jobs: the operand sum c+d, which is written to register y, and the final sum x+y, which is written to register z. An input mux in front of the adder and a demux behind it steer the data. Load-enabled registers hold a, b, c, d, x, y and z. A small state machine drives every load enable and every steering select.

Operand sets enter through a valid/ready handshake. Each result leaves as a one-cycle strobe together with a held value. A mode input selects one of two schedules:

- **Serial schedule:** one set is finished before the next one starts.
- **Overlapped schedule:** the final add of one set runs in the same cycle as the first multiply cycle of the next set.

The mode is read only when a set is taken while the unit is idle. The chosen schedule then stays in force until the unit drains.

Top module: `madd_top`

## Requirements
- R1: While reset is held, and at release, in_ready is 1, z_valid is 0 and z_o is 0.
- R2: Each accepted set (op_a, op_b, op_c, op_d) produces z_o = op_a*op_b + op_c + op_d modulo 2^(2*OPW). Results come out in acceptance order, and z_o keeps its value in every cycle that z_valid is 0.
- R3: Serial schedule (mode_i = 0 when latched): after an accept, in_ready is 0 for exactly two cycles. It is 1 in the third cycle, where the next set may be taken. If no set is taken there, in_ready stays 1 (idle).
- R4: Overlapped schedule (mode_i = 1 when latched): after an accept, in_ready is 0 for one cycle and 1 in the second. If no set is taken in that second cycle, in_ready is 0 for one more cycle and then 1 (idle).
- R5: z_valid is 1 for exactly one cycle per accepted set, four cycles after that set's accept cycle, in both schedules.
- R6: mode_i is latched only by an accept made while idle. Changes of mode_i while sets are in flight have no effect on timing or results until the unit is idle again.
- R7: When n sets are offered back to back from idle, the last z_valid comes 3n+1 cycles after the first accept cycle in the serial schedule, and 2n+2 cycles after it in the overlapped schedule. The unit is therefore busy for 3n and 2n+1 cycles respectively.
- R8: Operand values and in_valid presented while in_ready is 0 are ignored and do not change any result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | Schedule select: 0 serial, 1 overlapped (read at an idle accept) |
| in_valid | input | 1 | Operand set offered |
| in_ready | output | 1 | Operand set can be taken this cycle |
| op_a | input | OPW | Multiplicand |
| op_b | input | OPW | Multiplier |
| op_c | input | OPW | First addend |
| op_d | input | OPW | Second addend |
| z_valid | output | 1 | One-cycle strobe: new result on z_o |
| z_o | output | 2*OPW | Result register |

## Verification
The bound checker watches four things on every cycle:

- The ready gap after each accept, in the form that applies to the latched schedule.
- The single-cycle shape of z_valid.
- That z_o holds between strobes.
- That the latched mode changes only on an accept.

Some behaviours need whole scenarios and are shown only by the bench's cycle-by-cycle reference model. These are:

- Arithmetic correctness, including the all-ones corner.
- The end-to-end burst lengths 3n+1 and 2n+2.
- Ignoring of mode flips and of operand noise while sets are in flight.
- Mixing of both schedules with irregular offers.

// File: rtl/madd_pkg.sv
package madd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,   // waiting for a set
        ST_MA,     // multiply cycle 1 (overlapped: final add of previous set)
        ST_MB,     // multiply cycle 2, c+d into y
        ST_ZS      // final add x+y into z
    } sched_st_e;

    // steering encodings
    localparam logic SEL_CD = 1'b1;   // adder takes c,d
    localparam logic SEL_XY = 1'b0;   // adder takes x,y
    localparam logic DMX_Z  = 1'b1;   // adder result goes to z
    localparam logic DMX_Y  = 1'b0;   // adder result goes to y

    typedef struct packed {
        logic in_ready;
        logic ld_ops;
        logic mul_cap;
        logic ld_x;
        logic add_go;
        logic add_sel;
        logic dmx_sel;
    } ctrl_t;

endpackage

// File: rtl/madd_mul2.sv
module madd_mul2 #(
    parameter int OPW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cap,
    input  logic [OPW-1:0]       a,
    input  logic [OPW-1:0]       b,
    output logic [2*OPW-1:0]     prod
);
    localparam int LOW  = OPW / 2;
    localparam int HIW  = OPW - LOW;
    localparam int XW   = 2 * OPW;
    localparam int PLW  = OPW + LOW;
    localparam int PHW  = OPW + HIW;

    typedef struct packed {
        logic [PLW-1:0] pl;
        logic [PHW-1:0] ph;
    } part_t;

    part_t p_d, p_q;

    always_comb begin
        p_d = p_q;
        if (cap) begin
            p_d.pl = PLW'(a) * PLW'(b[LOW-1:0]);
            p_d.ph = PHW'(a) * PHW'(b[OPW-1:LOW]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign prod = XW'(p_q.pl) + (XW'(p_q.ph) << LOW);

endmodule

// File: rtl/madd_addsh.sv
module madd_addsh #(
    parameter int XW = 32
) (
    input  logic          go,
    input  logic          sel,
    input  logic          dmx,
    input  logic [XW-1:0] in_x,
    input  logic [XW-1:0] in_y,
    input  logic [XW-1:0] in_c,
    input  logic [XW-1:0] in_d,
    output logic [XW-1:0] sum,
    output logic          z_we,
    output logic          y_we
);
    import madd_pkg::*;

    logic [XW-1:0] opl, opr;

    always_comb begin
        opl  = (sel == SEL_CD) ? in_c : in_x;
        opr  = (sel == SEL_CD) ? in_d : in_y;
        sum  = opl + opr;
        z_we = go && (dmx == DMX_Z);
        y_we = go && (dmx == DMX_Y);
    end

endmodule

// File: rtl/madd_ctrl.sv
module madd_ctrl (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             mode_i,
    output madd_pkg::ctrl_t  ctl,
    output logic             mode_q
);
    import madd_pkg::*;

    typedef struct packed {
        sched_st_e st;
        logic      zpend;
        logic      ovl;
    } fsm_t;

    fsm_t s_d, s_q;

    always_comb begin
        s_d         = s_q;
        ctl         = '0;
        ctl.add_sel = SEL_XY;
        ctl.dmx_sel = DMX_Y;
        unique case (s_q.st)
            ST_IDLE: begin
                ctl.in_ready = 1'b1;
                if (in_valid) begin
                    ctl.ld_ops = 1'b1;
                    s_d.ovl    = mode_i;
                    s_d.zpend  = 1'b0;
                    s_d.st     = ST_MA;
                end
            end
            ST_MA: begin
                ctl.mul_cap = 1'b1;
                if (s_q.zpend) begin
                    ctl.add_go  = 1'b1;
                    ctl.add_sel = SEL_XY;
                    ctl.dmx_sel = DMX_Z;
                end
                s_d.zpend = 1'b0;
                s_d.st    = ST_MB;
            end
            ST_MB: begin
                ctl.ld_x    = 1'b1;
                ctl.add_go  = 1'b1;
                ctl.add_sel = SEL_CD;
                ctl.dmx_sel = DMX_Y;
                s_d.st      = ST_ZS;
                if (s_q.ovl) begin
                    ctl.in_ready = 1'b1;
                    if (in_valid) begin
                        ctl.ld_ops = 1'b1;
                        s_d.zpend  = 1'b1;
                        s_d.st     = ST_MA;
                    end
                end
            end
            ST_ZS: begin
                ctl.add_go  = 1'b1;
                ctl.add_sel = SEL_XY;
                ctl.dmx_sel = DMX_Z;
                s_d.st      = ST_IDLE;
                if (!s_q.ovl) begin
                    ctl.in_ready = 1'b1;
                    if (in_valid) begin
                        ctl.ld_ops = 1'b1;
                        s_d.st     = ST_MA;
                    end
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: ST_IDLE, zpend: 1'b0, ovl: 1'b0};
        else        s_q <= s_d;
    end

    assign mode_q = s_q.ovl;

endmodule

// File: rtl/madd_top.sv
module madd_top #(
    parameter int OPW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mode_i,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [OPW-1:0]       op_a,
    input  logic [OPW-1:0]       op_b,
    input  logic [OPW-1:0]       op_c,
    input  logic [OPW-1:0]       op_d,
    output logic                 z_valid,
    output logic [2*OPW-1:0]     z_o
);
    import madd_pkg::*;

    localparam int XW = 2 * OPW;

    typedef struct packed {
        logic [OPW-1:0] a;
        logic [OPW-1:0] b;
        logic [OPW-1:0] c;
        logic [OPW-1:0] d;
        logic [XW-1:0]  x;
        logic [XW-1:0]  y;
        logic [XW-1:0]  z;
        logic           zv;
    } dp_t;

    dp_t            r_d, r_q;
    ctrl_t          ctl;
    logic           mode_q;
    logic [XW-1:0]  mul_x;
    logic [XW-1:0]  add_sum;
    logic           z_we, y_we;

    madd_ctrl i_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .mode_i   (mode_i),
        .ctl      (ctl),
        .mode_q   (mode_q)
    );

    madd_mul2 #(.OPW(OPW)) i_mul (
        .clk   (clk),
        .rst_n (rst_n),
        .cap   (ctl.mul_cap),
        .a     (r_q.a),
        .b     (r_q.b),
        .prod  (mul_x)
    );

    madd_addsh #(.XW(XW)) i_add (
        .go    (ctl.add_go),
        .sel   (ctl.add_sel),
        .dmx   (ctl.dmx_sel),
        .in_x  (r_q.x),
        .in_y  (r_q.y),
        .in_c  (XW'(r_q.c)),
        .in_d  (XW'(r_q.d)),
        .sum   (add_sum),
        .z_we  (z_we),
        .y_we  (y_we)
    );

    always_comb begin
        r_d    = r_q;
        r_d.zv = z_we;
        if (ctl.ld_ops) begin
            r_d.a = op_a;
            r_d.b = op_b;
            r_d.c = op_c;
            r_d.d = op_d;
        end
        if (ctl.ld_x) r_d.x = mul_x;
        if (y_we)     r_d.y = add_sum;
        if (z_we)     r_d.z = add_sum;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign in_ready = ctl.in_ready;
    assign z_valid  = r_q.zv;
    assign z_o      = r_q.z;

endmodule

// File: rtl/madd_chk.sv
module madd_chk #(
    parameter int XW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          in_ready,
    input logic          z_valid,
    input logic [XW-1:0] z_o,
    input logic          mode_q
);
    logic acc;
    assign acc = in_valid && in_ready;

    // R3/R4: the cycle after any accept never offers ready
    assert_accept_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> !in_ready);

    // R3: serial schedule keeps ready low two cycles after an accept
    assert_serial_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_q && $past(acc, 2)) |-> !in_ready);

    // R4: overlapped schedule offers ready two cycles after an accept
    assert_overlap_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q && $past(acc, 2)) |-> in_ready);

    // R5: result strobe lasts one cycle
    assert_zvalid_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        z_valid |=> !z_valid);

    // R2: result holds between strobes
    assert_z_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !z_valid |-> $stable(z_o));

    // R6: latched schedule only moves on an accept
    assert_mode_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> $stable(mode_q));

endmodule

bind madd_top madd_chk #(.XW(2*OPW)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .z_valid  (z_valid),
    .z_o      (z_o),
    .mode_q   (mode_q)
);

// File: tb/test_madd_top.sv
`timescale 1ns/1ps
module test_madd_top;
    localparam int OPW = 16;
    localparam int XW  = 2 * OPW;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           mode_i = 1'b0;
    logic           in_valid = 1'b0;
    logic           in_ready;
    logic [OPW-1:0] op_a = '0, op_b = '0, op_c = '0, op_d = '0;
    logic           z_valid;
    logic [XW-1:0]  z_o;

    always #2.5 clk = ~clk;

    madd_top #(.OPW(OPW)) i_madd_top (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .in_valid(in_valid),
        .in_ready(in_ready), .op_a(op_a), .op_b(op_b), .op_c(op_c), .op_d(op_d),
        .z_valid(z_valid), .z_o(z_o)
    );

    int            n_chk = 0, n_fail = 0;
    int            cyc = 0;
    logic [XW-1:0] exp_q[$];
    int            due_q[$];
    int            rdy_from = 0, gap_cyc = -1, idle_from = 0, last_zv = 0;
    bit            m_cur = 1'b0;
    bit            done = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
        end
    endtask

    function automatic logic [OPW-1:0] rnd16();
        return OPW'($urandom);
    endfunction

    // one cycle: compare outputs against the model, drive inputs, update model
    task automatic tick(input bit v, input bit m, input bit garb,
                        input logic [OPW-1:0] ia, ib, ic, id, output bit acc);
        bit mrdy, mzv;
        @(negedge clk);
        cyc++;
        mrdy = (cyc >= rdy_from) && (cyc != gap_cyc);
        chk(in_ready == mrdy, m_cur ? "R4 in_ready" : "R3 in_ready", 64'(in_ready), 64'(mrdy));
        mzv = (due_q.size() > 0) && (due_q[0] == cyc);
        chk(z_valid == mzv, "R5 z_valid", 64'(z_valid), 64'(mzv));
        if (mzv) begin
            chk(z_o == exp_q[0], "R2 z value", 64'(z_o), 64'(exp_q[0]));
            last_zv = cyc;
            void'(exp_q.pop_front());
            void'(due_q.pop_front());
        end
        in_valid = v;
        mode_i   = m;
        if (garb && !mrdy) begin  // R8: noise while not ready
            op_a = rnd16(); op_b = rnd16(); op_c = rnd16(); op_d = rnd16();
        end else begin
            op_a = ia; op_b = ib; op_c = ic; op_d = id;
        end
        acc = v && mrdy;
        if (acc) begin
            if (cyc >= idle_from) m_cur = m;
            exp_q.push_back(XW'(op_a) * XW'(op_b) + XW'(op_c) + XW'(op_d));
            due_q.push_back(cyc + 4);
            rdy_from  = cyc + (m_cur ? 2 : 3);
            gap_cyc   = m_cur ? cyc + 3 : -1;
            idle_from = cyc + 4;
        end
    endtask

    task automatic drain();
        bit acc;
        while (due_q.size() > 0) tick(1'b0, mode_i, 1'b0, rnd16(), rnd16(), rnd16(), rnd16(), acc);
        repeat (2) tick(1'b0, mode_i, 1'b0, rnd16(), rnd16(), rnd16(), rnd16(), acc);
    endtask

    // R7: back-to-back burst of n sets from idle; optionally flip mode_i (R6) and add noise (R8)
    task automatic burst(input int n, input bit m, input bit flip, input bit garb, input bit corner);
        logic [OPW-1:0] pa, pb, pc, pd;
        int taken = 0, first = 0, expd;
        bit acc, mm;
        pa = corner ? '1 : rnd16(); pb = corner ? '1 : rnd16();
        pc = corner ? '1 : rnd16(); pd = corner ? '1 : rnd16();
        while (taken < n) begin
            mm = (flip && taken > 0) ? ~m : m;
            tick(1'b1, mm, garb, pa, pb, pc, pd, acc);
            if (acc) begin
                if (taken == 0) first = cyc;
                taken++;
                if (corner && taken == 1) begin pa = '0; pb = '0; pc = '0; pd = '0; end
                else begin pa = rnd16(); pb = rnd16(); pc = rnd16(); pd = rnd16(); end
            end
        end
        drain();
        expd = m ? 2 * n + 2 : 3 * n + 1;
        chk(last_zv - first == expd, "R7 burst length", 64'(last_zv - first), 64'(expd));
    endtask

    initial begin
        bit acc;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(in_ready == 1'b1, "R1 in_ready", 64'(in_ready), 64'd1);
        chk(z_valid == 1'b0,  "R1 z_valid",  64'(z_valid),  64'd0);
        chk(z_o == '0,        "R1 z_o",      64'(z_o),      64'd0);
        rst_n = 1'b1;
        tick(1'b0, 1'b0, 1'b0, '0, '0, '0, '0, acc);
        chk(in_ready == 1'b1 && z_valid == 1'b0, "R1 after release", 64'({in_ready, z_valid}), 64'b10);

        burst(4, 1'b0, 1'b0, 1'b0, 1'b1);   // serial, corner operands: 4 sets -> 13
        burst(4, 1'b1, 1'b0, 1'b0, 1'b1);   // overlapped: 4 sets -> 10
        burst(1, 1'b0, 1'b0, 1'b0, 1'b0);
        burst(1, 1'b1, 1'b0, 1'b0, 1'b0);
        burst(7, 1'b1, 1'b1, 1'b1, 1'b0);   // R6 flip mode mid-burst, R8 noise
        burst(7, 1'b0, 1'b1, 1'b1, 1'b0);
        // irregular offers with mode changes in both schedules
        for (int i = 0; i < 600; i++) begin
            tick(1'($urandom % 3 != 0), 1'($urandom), 1'b1, rnd16(), rnd16(), rnd16(), rnd16(), acc);
        end
        drain();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule